// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block walks a ring of transmit buffer descriptors held in system memory and turns the buffers they point to into an outgoing byte stream. Software sets an enable bit, programs the ring start address and then pulses an activation strobe. The walker fetches the descriptor at its current pointer. If that descriptor is marked ready, the walker reads the referenced buffer word by word and emits its bytes. It then writes the descriptor back with the ready mark removed and steps to the next descriptor. The walk ends at the first descriptor that is not ready, and the pointer stays there for the next activation.

A frame can span several descriptors and ends at the one carrying the last-buffer mark. A frame has a hard byte cap. Any data past the cap is cut off and a babble event pulses. Three single-cycle event outputs report each finished descriptor, each finished frame and each clipping. One 32-bit memory master port with a request/acknowledge handshake carries all descriptor and buffer traffic.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `out_valid`, `out_last` and all event outputs are 0.
- R2: A strobe write (`reg_sel`=2) starts nothing, and no memory request appears, unless bit 1 of the control value (`reg_sel`=0) is set.
- R3: A descriptor is two big-endian 32-bit words. In word 0, bits 31:16 are the flags and bits 15:0 are the byte length. Word 1 is the buffer byte address. The buffer bytes leave on `out_data` in ascending address order, and the byte at an address whose low two bits are k sits in bits (31-8k):(24-8k) of its memory word. Every memory access is word aligned.
- R4: Flag bit 11 marks the last buffer of a frame. `out_last` is high with the final byte of such a descriptor, and `ev_frame` pulses once for it.
- R5: After a descriptor has been processed, word 0 is written back to the same address with flag bit 15 cleared. All other flag bits and the original length are kept.
- R6: After a descriptor whose flag bit 13 (wrap) is set, the next descriptor is read from the ring start. Otherwise it is read from the current address plus 8.
- R7: A fetched descriptor with flag bit 15 (ready) clear ends the walk. The next activation resumes at that same descriptor.
- R8: Writing the ring start (`reg_sel`=1) stores the value with bits 1:0 forced to 0 and reloads the current descriptor pointer.
- R9: When a frame's accumulated length would exceed FRAME_MAX (2032), the descriptor's length is clipped to the remaining room and `ev_babble` pulses. The count restarts after a last-buffer descriptor.
- R10: `ev_buf` pulses once for every processed descriptor, and bytes are emitted only while `busy` is high.
- R11: An enabled strobe that arrives during a walk is remembered. When the walk meets a not-ready descriptor, that descriptor is fetched again before the walker goes idle.
- R12: A memory request holds its address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 ring start, 2 activation strobe |
| reg_wdata | input | 32 | Register write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Byte valid |
| out_data | output | 8 | Byte |
| out_last | output | 1 | Final byte of a frame |
| ev_buf | output | 1 | Descriptor processed pulse |
| ev_frame | output | 1 | Frame finished pulse |
| ev_babble | output | 1 | Frame clipped pulse |
| busy | output | 1 | Walk in progress |

## Verification
The bench goes after an unaligned buffer start, a wrap back to the ring start, a resume from the stopping descriptor, and a second strobe that arrives while a walk is running. In that last case the bench makes the not-ready descriptor ready just after it has been read. A walker that dropped the remembered strobe would therefore lose those bytes, and a walker that ignored wrap or reset its pointer would stream the wrong buffers. A 2000-byte buffer followed by a 100-byte last buffer checks the cap. A walker that failed to clip would emit 68 extra bytes, and one that did not restart its count would clip the following frame as well. Descriptor write-back words are compared in memory to catch a wrong bit being cleared or a changed length.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DHDR, S_DPTR, S_DATA, S_STRM, S_WBACK
  } txr_state_t;
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
endpackage

// File: rtl/txr_clip.sv
module txr_clip #(
  parameter int LW  = 16,
  parameter int MAX = 2032,
  parameter int CW  = 11
) (
  input  logic [CW-1:0] used,
  input  logic [LW-1:0] req_len,
  output logic [LW-1:0] eff_len,
  output logic          clipped
);
  logic [31:0] room;
  always_comb begin
    room    = 32'(MAX) - 32'(used);
    clipped = 32'(req_len) > room;
    eff_len = clipped ? room[LW-1:0] : req_len;
  end
endmodule

// File: rtl/txr_lane.sv
module txr_lane #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int SW = $clog2(NB)
) (
  input  logic [DW-1:0] word,
  input  logic [SW-1:0] sel,
  output logic [7:0]    byte_o
);
  always_comb byte_o = word[(NB-1-int'(sel))*8 +: 8];
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
  import txr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int FRAME_MAX = 2032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble,
  output logic          busy
);
  localparam int NB = DW / 8;
  localparam int SW = $clog2(NB);
  localparam int LW = 16;
  localparam int CW = $clog2(FRAME_MAX + 1);

  txr_state_t    state;
  logic          en, pend;
  logic [AW-1:0] ring_base, cur_ptr, bptr;
  logic [15:0]   flags_r;
  logic [LW-1:0] len_r, rem;
  logic [CW-1:0] frame_used;
  logic [DW-1:0] wbuf;
  logic [LW-1:0] eff_len;
  logic          clipped;
  logic [7:0]    lane_byte;
  logic          kick_ok;
  logic [AW-1:0] bptr_nx;
  logic [AW-1:0] next_desc;

  txr_clip #(.LW(LW), .MAX(FRAME_MAX), .CW(CW)) u_clip (
    .used(frame_used), .req_len(mem_rdata[LW-1:0]),
    .eff_len(eff_len), .clipped(clipped)
  );

  txr_lane #(.DW(DW)) u_lane (
    .word(wbuf), .sel(bptr[SW-1:0]), .byte_o(lane_byte)
  );

  always_comb begin
    kick_ok   = reg_wr && (reg_sel == 2'd2) && en;
    bptr_nx   = bptr + AW'(1);
    next_desc = flags_r[FLG_WRAP] ? ring_base : cur_ptr + AW'(8);
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; en <= 1'b0; pend <= 1'b0;
      ring_base <= '0; cur_ptr <= '0; bptr <= '0;
      flags_r <= '0; len_r <= '0; rem <= '0; frame_used <= '0; wbuf <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      ev_buf <= 1'b0; ev_frame <= 1'b0; ev_babble <= 1'b0;
    end else begin
      out_valid <= 1'b0; out_last <= 1'b0;
      ev_buf <= 1'b0; ev_frame <= 1'b0; ev_babble <= 1'b0;
      if (reg_wr && reg_sel == 2'd0) en <= reg_wdata[1];
      if (kick_ok && state != S_IDLE) pend <= 1'b1;
      case (state)
        S_IDLE: if (kick_ok) begin
          state <= S_DHDR; mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= cur_ptr;
        end
        S_DHDR: if (mem_ack) begin
          flags_r <= mem_rdata[31:16];
          len_r   <= mem_rdata[LW-1:0];
          if (!mem_rdata[16+FLG_READY]) begin
            if (pend || kick_ok) pend <= 1'b0;
            else begin
              mem_req <= 1'b0; state <= S_IDLE;
            end
          end else begin
            rem        <= eff_len;
            ev_babble  <= clipped;
            frame_used <= mem_rdata[16+FLG_LAST] ? '0 : frame_used + CW'(eff_len);
            mem_addr   <= cur_ptr + AW'(4);
            state      <= S_DPTR;
          end
        end
        S_DPTR: if (mem_ack) begin
          bptr <= mem_rdata[AW-1:0];
          if (rem == '0) begin
            mem_we <= 1'b1; mem_addr <= cur_ptr;
            mem_wdata <= {flags_r & ~(16'h1 << FLG_READY), len_r};
            state <= S_WBACK;
          end else begin
            mem_addr <= {mem_rdata[AW-1:SW], {SW{1'b0}}};
            state <= S_DATA;
          end
        end
        S_DATA: if (mem_ack) begin
          wbuf <= mem_rdata; mem_req <= 1'b0; state <= S_STRM;
        end
        S_STRM: begin
          out_valid <= 1'b1;
          out_data  <= lane_byte;
          out_last  <= (rem == LW'(1)) && flags_r[FLG_LAST];
          bptr      <= bptr_nx;
          rem       <= rem - LW'(1);
          if (rem == LW'(1)) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur_ptr;
            mem_wdata <= {flags_r & ~(16'h1 << FLG_READY), len_r};
            state <= S_WBACK;
          end else if (bptr[SW-1:0] == {SW{1'b1}}) begin
            mem_req <= 1'b1; mem_we <= 1'b0;
            mem_addr <= {bptr_nx[AW-1:SW], {SW{1'b0}}};
            state <= S_DATA;
          end
        end
        S_WBACK: if (mem_ack) begin
          ev_buf   <= 1'b1;
          ev_frame <= flags_r[FLG_LAST];
          cur_ptr  <= next_desc;
          mem_we   <= 1'b0; mem_addr <= next_desc;
          state    <= S_DHDR;
        end
        default: state <= S_IDLE;
      endcase
      if (reg_wr && reg_sel == 2'd1) begin
        ring_base <= {reg_wdata[AW-1:2], 2'b00};
        cur_ptr   <= {reg_wdata[AW-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        out_valid,
  input logic        out_last,
  input logic        ev_buf,
  input logic        ev_frame,
  input logic        busy
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r4_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  a_r4_frame_with_buf: assert property (@(posedge clk) disable iff (rst)
    ev_frame |-> ev_buf);
  a_r2_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  a_r10_bytes_when_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
endmodule

bind txdesc_ring_engine txr_checker u_txr_checker (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .out_valid(out_valid),
  .out_last(out_last), .ev_buf(ev_buf), .ev_frame(ev_frame), .busy(busy)
);

// File: tb/tb_txdesc_ring_engine.sv
module tb_txdesc_ring_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic out_valid, out_last, ev_buf, ev_frame, ev_babble, busy;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  txdesc_ring_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble),
    .busy(busy)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mem [int unsigned];
  logic [8:0] expq [$];
  int req_cnt = 0, buf_cnt = 0, frm_cnt = 0, bab_cnt = 0;
  bit watch_arm = 0;
  logic [31:0] watch_addr, watch_val;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {pat(a), pat(a + 1), pat(a + 2), pat(a + 3)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      req_cnt++;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        mem_rdata <= rd_word(mem_addr);
        if (watch_arm && mem_addr == watch_addr) begin
          mem[watch_addr] = watch_val;
          watch_arm = 0;
        end
      end
    end else mem_ack <= 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (ev_buf) buf_cnt++;
      if (ev_frame) frm_cnt++;
      if (ev_babble) bab_cnt++;
      if (out_valid) begin
        if (expq.size() == 0) check(0, "R3 unexpected byte", {23'b0, out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({out_last, out_data} == e, "R3/R4 byte or last", {23'b0, out_last, out_data}, {23'b0, e});
        end
      end
    end
  end

  task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [15:0] f, input logic [15:0] l, input logic [31:0] p);
    mem[a] = {f, l};
    mem[a + 4] = p;
  endtask

  task automatic expect_buf(input logic [31:0] p, input int len, input bit last);
    for (int i = 0; i < len; i++) expq.push_back({last && (i == len - 1), pat(p + i)});
  endtask

  task automatic clr_ev();
    buf_cnt = 0; frm_cnt = 0; bab_cnt = 0;
  endtask

  task automatic wait_done();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R3 all bytes emitted", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!busy && !mem_req && !out_valid && !out_last, "R1 reset idle",
          {busy, mem_req, out_valid, out_last}, 0);
    check(!ev_buf && !ev_frame && !ev_babble, "R1 events low", {ev_buf, ev_frame, ev_babble}, 0);

    // R2: strobe while disabled
    set_desc(32'h1000, 16'h8800, 16'd4, 32'h9000);
    write_reg(2'd1, 32'h1000);
    write_reg(2'd2, 0);
    repeat (10) @(negedge clk);
    check(req_cnt == 0 && !busy, "R2 disabled strobe ignored", req_cnt, 0);
    check(out_valid == 0, "R2 no bytes", out_valid, 0);

    // R8 + R3 + R4: chain of two, unaligned buffer
    write_reg(2'd1, 32'h1003);
    set_desc(32'h1000, 16'h8000, 16'd5, 32'h2001);
    set_desc(32'h1008, 16'h8800, 16'd6, 32'h3000);
    set_desc(32'h1010, 16'h0000, 16'd3, 32'h4000);
    write_reg(2'd0, 32'h2);
    clr_ev();
    expect_buf(32'h2001, 5, 0);
    expect_buf(32'h3000, 6, 1);
    write_reg(2'd2, 0);
    wait_done();
    check(buf_cnt == 2, "R10 buffer events", buf_cnt, 2);
    check(frm_cnt == 1, "R4 frame events", frm_cnt, 1);
    check(mem[32'h1000] == 32'h0000_0005, "R5 writeback first", mem[32'h1000], 32'h0000_0005);
    check(mem[32'h1008] == 32'h0800_0006, "R5 writeback second", mem[32'h1008], 32'h0800_0006);
    check(mem[32'h1010] == 32'h0000_0003, "R7 not-ready untouched", mem[32'h1010], 32'h0000_0003);

    // R7 resume + R6 wrap
    set_desc(32'h1010, 16'hA800, 16'd3, 32'h4000);
    set_desc(32'h1000, 16'h8800, 16'd2, 32'h5000);
    clr_ev();
    expect_buf(32'h4000, 3, 1);
    expect_buf(32'h5000, 2, 1);
    write_reg(2'd2, 0);
    wait_done();
    check(buf_cnt == 2 && frm_cnt == 2, "R6 wrap walk events", {buf_cnt[15:0], frm_cnt[15:0]}, 32'h0002_0002);
    check(mem[32'h1010] == 32'h2800_0003, "R5 wrap flag kept", mem[32'h1010], 32'h2800_0003);

    // R11: strobe during walk, descriptor made ready after its not-ready read
    set_desc(32'h1008, 16'h8800, 16'd40, 32'h6000);
    mem[32'h1014] = 32'h7000;
    watch_addr = 32'h1010; watch_val = 32'hA800_0004; watch_arm = 1;
    clr_ev();
    expect_buf(32'h6000, 40, 1);
    expect_buf(32'h7000, 4, 1);
    write_reg(2'd2, 0);
    repeat (5) @(negedge clk);
    check(busy, "R11 walk running", busy, 1);
    write_reg(2'd2, 0);
    wait_done();
    check(buf_cnt == 2, "R11 rescan processed", buf_cnt, 2);

    // R9 frame cap
    write_reg(2'd1, 32'h0802);
    set_desc(32'h0800, 16'h8000, 16'd2000, 32'h10000);
    set_desc(32'h0808, 16'h8800, 16'd100, 32'h20000);
    set_desc(32'h0810, 16'h8800, 16'd50, 32'h30000);
    set_desc(32'h0818, 16'h0000, 16'd1, 32'h0);
    clr_ev();
    expect_buf(32'h10000, 2000, 0);
    expect_buf(32'h20000, 32, 1);
    expect_buf(32'h30000, 50, 1);
    write_reg(2'd2, 0);
    wait_done();
    check(bab_cnt == 1, "R9 babble once", bab_cnt, 1);
    check(buf_cnt == 3 && frm_cnt == 2, "R10 cap events", {buf_cnt[15:0], frm_cnt[15:0]}, 32'h0003_0002);
    check(mem[32'h0808] == 32'h0800_0064, "R9 writeback keeps length", mem[32'h0808], 32'h0800_0064);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule